// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction per clock. It runs a small load/store instruction subset: word load and store, the register-to-register operations add, subtract, AND, OR and signed set-less-than, branch-if-equal, and an absolute jump. Instruction memory and data memory are separate. Both are read combinationally within the cycle. A data store and a register write take effect on the rising clock edge that ends the instruction.

Decoding happens in two levels. The main decoder looks at the 6-bit opcode. It produces the datapath steering signals and a 2-bit operation class. A second decoder combines that class with the 6-bit function field to select one of five 3-bit ALU operations. The ALU's zero flag resolves branch-if-equal.

All ports are plain control and data pins. The memories answer in the same cycle, so the core never stalls and has no back-pressure. A surrounding system supplies the instruction word for `imem_addr` and the load data for `dmem_addr` combinationally.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. The first instruction after reset is fetched from address 0.
- R2: For every instruction that is not a branch or jump, the next fetch address is the current address plus 4. This includes a branch that is not taken.
- R3: A load (opcode 35, base in bits [25:21], destination in bits [20:16], offset in [15:0]) reads data memory at base plus the sign-extended offset and writes the word to the destination register. Negative offsets are supported.
- R4: A store (opcode 43) raises `dmem_we` for one cycle, with `dmem_addr` set to base plus the sign-extended offset and `dmem_wdata` set to the register named in bits [20:16]. No other instruction raises `dmem_we`.
- R5: An R-type instruction (opcode 0, sources in [25:21] and [20:16], destination in [15:11]) with function 100000 writes the sum of its sources, and with function 100010 writes the first source minus the second.
- R6: R-type function 100100 writes the bitwise AND of the sources, and function 100101 writes the bitwise OR.
- R7: R-type function 101010 writes 1 when the first source is less than the second as signed two's-complement numbers, and writes 0 otherwise.
- R8: Branch-if-equal (opcode 4) compares the two source registers. When they are equal, the next fetch address is the current address plus 4 plus the sign-extended offset shifted left by 2, so backward targets are possible. When they differ, the next fetch address is the current address plus 4.
- R9: Jump (opcode 2) sets the next fetch address to bits [31:28] of (current address plus 4), followed by instruction bits [25:0], followed by two zero bits.
- R10: Register 0 always reads as zero, and a write to it has no effect.
- R11: When an instruction writes a register that it also reads, the read uses the value from before the instruction. The new value is visible to the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
Two things can happen in the same cycle: a register write-back and a read of that same register. An instruction such as add r3,r3,r1 reads its source during the cycle and writes the sum at the closing edge. The bench provokes this and then stores r3. The expected value is the old r3 plus r1 exactly once, which shows that the read saw the pre-edge value and the next instruction saw the new one. Branch and jump outcomes are judged by comparing every fetch address against a precomputed trace. This includes a taken branch that skips a store, so the scoreboard also flags any store that should not appear.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_FUNCT  = 2'b10,
    CLS_RSVD   = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic      dst_is_rd;
    logic      b_is_imm;
    logic      wb_from_mem;
    logic      reg_we;
    logic      mem_we;
    logic      is_branch;
    logic      is_jump;
    op_class_e op_class;
  } ctrl_t;
endpackage

// File: rtl/sc_main_decode.sv
module sc_main_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
             reg_we: 1'b0, mem_we: 1'b0, is_branch: 1'b0,
             is_jump: 1'b0, op_class: CLS_MEM};
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        ctrl.op_class  = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.op_class  = CLS_BRANCH;
      end
      OPC_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_decode.sv
module sc_alu_decode
  import sc_pkg::*;
(
  input  op_class_e  op_class,
  input  logic [5:0] funct,
  output alu_op_e    alu_op
);
  always_comb begin
    unique case (op_class)
      CLS_MEM:    alu_op = ALU_ADD;
      CLS_BRANCH: alu_op = ALU_SUB;
      CLS_FUNCT: begin
        unique case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      default:    alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff = a - b;
  // Signed compare from the sign bits and the difference, immune to overflow.
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      regs[r] <= '0;
      else if (we && wa == AW'(r))     regs[r] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int AW = $clog2(NREG);

  logic [31:0] pc_q, pc_next, pc_seq, br_target, jmp_target;
  logic [31:0] imm_ext, src_a, src_b, alu_b, alu_y, wb_data;
  logic [5:0]  opcode, funct;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [AW-1:0] wr_idx;
  logic        alu_zero;
  ctrl_t       ctrl;
  alu_op_e     alu_op;
  logic [4:0]  unused_shamt;

  assign opcode       = imem_rdata[31:26];
  assign f_rs         = imem_rdata[25:21];
  assign f_rt         = imem_rdata[20:16];
  assign f_rd         = imem_rdata[15:11];
  assign unused_shamt = imem_rdata[10:6];
  assign funct        = imem_rdata[5:0];
  assign imm_ext      = {{16{imem_rdata[15]}}, imem_rdata[15:0]};

  sc_main_decode u_mdec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sc_alu_decode u_adec (
    .op_class (ctrl.op_class),
    .funct    (funct),
    .alu_op   (alu_op)
  );

  assign wr_idx = AW'(ctrl.dst_is_rd ? f_rd : f_rt);

  sc_regfile #(.W(32), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (AW'(f_rs)),
    .ra2   (AW'(f_rt)),
    .rd1   (src_a),
    .rd2   (src_b),
    .we    (ctrl.reg_we),
    .wa    (wr_idx),
    .wd    (wb_data)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : src_b;

  sc_alu #(.W(32)) u_alu (
    .a    (src_a),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  assign pc_seq     = pc_q + 32'd4;
  assign br_target  = pc_seq + {imm_ext[29:0], 2'b00};
  assign jmp_target = {pc_seq[31:28], imem_rdata[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)                    pc_next = jmp_target;
    else if (ctrl.is_branch && alu_zero) pc_next = br_target;
    else                                 pc_next = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = src_b;
  assign dmem_we    = ctrl.mem_we & rst_n;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we
);
  logic        hist_ok;
  logic [5:0]  opc;
  logic [31:0] off4;

  assign opc  = imem_rdata[31:26];
  assign off4 = {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_ok <= 1'b0;
    else        hist_ok <= 1'b1;
  end

  a_r1_reset_pc: assert property (@(posedge clk)
    !rst_n |-> (imem_addr == 32'h0 && !dmem_we));

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(opc) != 6'd4 && $past(opc) != 6'd2)
      |-> imem_addr == $past(imem_addr) + 32'd4);

  a_r4_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> opc == 6'd43);

  a_r8_branch_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(opc) == 6'd4)
      |-> (imem_addr == $past(imem_addr) + 32'd4 ||
           imem_addr == $past(imem_addr) + 32'd4 + $past(off4)));

  a_r9_jump_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(opc) == 6'd2)
      |-> imem_addr == {$past(imem_addr[31:28] + 4'(imem_addr[27:2] == 26'h3ffffff)),
                        $past(imem_rdata[25:0]), 2'b00});
endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic        run;

  int checks = 0;
  int errors = 0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } st_exp_t;

  st_exp_t     st_q[$];
  logic [31:0] pc_q[$];

  sc_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_st(input logic [31:0] a, input logic [31:0] d, input string t);
    st_exp_t e;
    e.addr = a; e.data = d; e.tag = t;
    st_q.push_back(e);
  endtask

  task automatic load_program();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'h0000_0005;
    dmem[1] = 32'hFFFF_FFF0;
    dmem[2] = 32'h1234_5678;
    imem[0]  = enc_i(6'd35, 0, 1, 0);
    imem[1]  = enc_i(6'd35, 0, 2, 4);
    imem[2]  = enc_i(6'd35, 0, 3, 8);
    imem[3]  = enc_r(1, 2, 4, 6'b100000);
    imem[4]  = enc_i(6'd43, 0, 4, 16);
    imem[5]  = enc_r(1, 2, 5, 6'b100010);
    imem[6]  = enc_i(6'd43, 0, 5, 20);
    imem[7]  = enc_r(3, 2, 6, 6'b100100);
    imem[8]  = enc_i(6'd43, 0, 6, 24);
    imem[9]  = enc_r(1, 3, 7, 6'b100101);
    imem[10] = enc_i(6'd43, 0, 7, 28);
    imem[11] = enc_r(2, 1, 8, 6'b101010);
    imem[12] = enc_i(6'd43, 0, 8, 32);
    imem[13] = enc_r(1, 2, 9, 6'b101010);
    imem[14] = enc_i(6'd43, 0, 9, 36);
    imem[15] = enc_r(1, 1, 0, 6'b100000);
    imem[16] = enc_i(6'd43, 0, 0, 40);
    imem[17] = enc_r(0, 2, 12, 6'b100010);
    imem[18] = enc_i(6'd43, 12, 1, -4);
    imem[19] = enc_r(3, 1, 3, 6'b100000);
    imem[20] = enc_i(6'd43, 0, 3, 44);
    imem[21] = enc_i(6'd4, 1, 2, 5);
    imem[22] = enc_i(6'd4, 8, 8, 2);
    imem[23] = enc_i(6'd43, 0, 1, 48);
    imem[24] = enc_i(6'd43, 0, 1, 48);
    imem[25] = {6'd2, 26'd28};
    imem[26] = enc_i(6'd43, 0, 2, 52);
    imem[27] = enc_i(6'd43, 0, 2, 52);
    imem[28] = enc_i(6'd4, 0, 0, 1);
    imem[29] = enc_i(6'd43, 0, 2, 56);
    imem[30] = enc_i(6'd4, 0, 0, -1);

    push_st(32'd16, 32'hFFFF_FFF5, "R5 add (loads R3)");
    push_st(32'd20, 32'h0000_0015, "R5 sub");
    push_st(32'd24, 32'h1234_5670, "R6 and");
    push_st(32'd28, 32'h1234_567D, "R6 or");
    push_st(32'd32, 32'h0000_0001, "R7 slt signed true");
    push_st(32'd36, 32'h0000_0000, "R7 slt false");
    push_st(32'd40, 32'h0000_0000, "R10 r0 write ignored");
    push_st(32'd12, 32'h0000_0005, "R3 R4 negative offset");
    push_st(32'd44, 32'h1234_567D, "R11 read before write");

    for (int i = 0; i <= 22; i++) pc_q.push_back(32'(4 * i));
    pc_q.push_back(32'd100);
    pc_q.push_back(32'd112);
    pc_q.push_back(32'd120);
    pc_q.push_back(32'd120);
    pc_q.push_back(32'd120);
  endtask

  initial begin : monitor
    wait (run);
    forever begin
      @(negedge clk);
      #1;
      if (pc_q.size() > 0) check("R2 R8 R9 fetch address", imem_addr, pc_q.pop_front());
      if (dmem_we) begin
        if (st_q.size() == 0) begin
          check("R4 R8 unexpected store addr", dmem_addr, 32'hFFFF_FFFF);
        end else begin
          st_exp_t e;
          e = st_q.pop_front();
          check({e.tag, " addr"}, dmem_addr, e.addr);
          check({e.tag, " data"}, dmem_wdata, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    run   = 1'b0;
    rst_n = 1'b0;
    load_program();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset fetch address", imem_addr, 32'h0);
    check("R1 reset no store", {31'd0, dmem_we}, 32'd0);
    @(posedge clk);
    run = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    #2;
    check("R2 pc trace consumed", 32'(pc_q.size()), 32'd0);
    check("R4 all stores seen", 32'(st_q.size()), 32'd0);
    check("R3 R4 memory word at 12", dmem[3], 32'h0000_0005);
    check("R8 skipped store left 48", dmem[12], 32'h0);
    check("R9 skipped store left 52", dmem[13], 32'h0);
    check("R8 skipped store left 56", dmem[14], 32'h0);
    check("R8 self loop holds", imem_addr, 32'd120);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule